// File: doc/BRIEF.md
# Operand Stack Execution Unit

This block executes the data operations of a stack-oriented instruction set. It keeps its working values in a small on-chip operand stack and takes already-decoded instructions through a valid/ready handshake. The operands of arithmetic are implicit: they are always the entries at the top of the stack. The instructions are load-to-stack, store-from-stack, duplicate-top and the binary operations add, subtract and multiply.

Loads and stores go out on a word-addressed data memory port. The unit raises a request and holds it until memory answers with a ready pulse. Duplicate and arithmetic complete in the cycle in which they are accepted.

A push onto a full stack, or a pop that needs more entries than the stack holds, leaves the stack untouched. Instead it sets a sticky error flag. The current stack depth and the top value are visible on the ports, so a surrounding pipeline can observe them.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset, `depth` is 0, `err_ovf` and `err_unf` are 0, `insn_ready` is 1, `mem_req` is 0 and `top_value` is 0.
- R2: A load (op 0) accepted on a non-full stack raises `mem_req` with `mem_we`=0 and `mem_addr` equal to the accepted `insn_addr`, and keeps request, address and direction steady until `mem_ready`. The `mem_rdata` sampled on the `mem_ready` cycle becomes the new top, and `depth` grows by one.
- R3: A load or duplicate issued when `depth` equals the stack depth (8) issues no memory request and changes neither `depth` nor any entry. It sets `err_ovf`, which then stays 1 until reset.
- R4: A store (op 1) accepted on a non-empty stack raises `mem_req` with `mem_we`=1, `mem_addr` equal to `insn_addr` and `mem_wdata` equal to the top entry, holds them until `mem_ready`, and then removes the top entry.
- R5: A store or duplicate on an empty stack, or a binary operation with fewer than two entries, issues no memory request and leaves the stack unchanged. It sets `err_unf`, which then stays 1 until reset.
- R6: Duplicate (op 2) pushes a copy of the top entry in the accept cycle, without consuming it. Afterwards `depth` is one larger and the two top entries are equal.
- R7: The binary operations (op 3 add, op 4 subtract, op 5 multiply) take the second entry from the top as the left operand and the top entry as the right operand. They replace both entries with the low 32 bits of the result, in the accept cycle, so `depth` falls by one.
- R8: `insn_ready` is 1 exactly when the unit is idle. It is 0 while a memory operation waits, and it stays 1 across back-to-back single-cycle operations.
- R9: Op codes 6 and 7 are accepted and have no effect on the stack, the flags or the memory port.
- R10: `top_value` always shows the top entry, and shows 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | A decoded instruction is offered |
| insn_ready | output | 1 | Unit is idle and takes the instruction |
| insn_op | input | 3 | Operation code (0 load, 1 store, 2 dup, 3 add, 4 sub, 5 mul) |
| insn_addr | input | AW (4) | Word address for load and store |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW (4) | Word address of the access |
| mem_wdata | output | DW (32) | Data to write |
| mem_rdata | input | DW (32) | Read data, taken on the `mem_ready` cycle |
| mem_ready | input | 1 | Memory completes the pending access |
| depth | output | $clog2(DEPTH+1) (4) | Number of valid stack entries |
| top_value | output | DW (32) | Top entry, 0 when empty |
| err_ovf | output | 1 | Sticky overflow flag |
| err_unf | output | 1 | Sticky underflow flag |

## Verification
The bound checker watches several properties on every cycle:
- a pending request holds its address and direction until `mem_ready`;
- `insn_ready` is never high while a request is pending;
- the write data always equals the visible top;
- depth never exceeds the stack size and moves by at most one per cycle;
- both error flags stay set once set.

The arithmetic results and their operand order cannot be checked that way, and neither can the exact values pushed by loads and duplicates or the no-effect cases for illegal pushes, pops and spare op codes. The bench shows these through its scenarios: it fills the stack, overflows and underflows it, and sweeps every operation over a set of corner operand pairs with varied memory wait states.

// File: rtl/stkx_pkg.sv
package stkx_pkg;

   typedef enum logic [2:0] {
      OPC_LOAD  = 3'd0,
      OPC_STORE = 3'd1,
      OPC_DUP   = 3'd2,
      OPC_ADD   = 3'd3,
      OPC_SUB   = 3'd4,
      OPC_MUL   = 3'd5
   } stk_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } stk_state_e;

endpackage

// File: rtl/stkx_store.sv
module stkx_store #(
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   parameter int SPW   = $clog2(DEPTH + 1),
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           wr_en,
   input  logic [IW-1:0]  wr_idx,
   input  logic [DW-1:0]  wr_data,
   input  logic [SPW-1:0] sp,
   output logic [DW-1:0]  top_q,
   output logic [DW-1:0]  next_q
);
   logic [DW-1:0]  cells [DEPTH];
   logic [SPW-1:0] top_i;
   logic [SPW-1:0] next_i;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IW'(g))) q <= wr_data;
      end
      assign cells[g] = q;
   end

   assign top_i  = sp - SPW'(1);
   assign next_i = sp - SPW'(2);
   assign top_q  = (sp == '0) ? '0 : cells[top_i[IW-1:0]];
   assign next_q = cells[next_i[IW-1:0]];
endmodule

// File: rtl/stkx_alu.sv
module stkx_alu #(
   parameter int DW = 32
) (
   input  logic [2:0]    op,
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   output logic [DW-1:0] res
);
   import stkx_pkg::*;

   always_comb begin
      case (stk_op_e'(op))
         OPC_ADD: res = lhs + rhs;
         OPC_SUB: res = lhs - rhs;
         OPC_MUL: res = lhs * rhs;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/stkx_ctrl.sv
module stkx_ctrl #(
   parameter int DW    = 32,
   parameter int AW    = 4,
   parameter int DEPTH = 8,
   parameter int SPW   = $clog2(DEPTH + 1),
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           insn_valid,
   input  logic [2:0]     insn_op,
   input  logic [AW-1:0]  insn_addr,
   input  logic           mem_ready,
   input  logic [DW-1:0]  mem_rdata,
   input  logic [DW-1:0]  top_q,
   input  logic [DW-1:0]  alu_res,
   output logic           insn_ready,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [SPW-1:0] sp,
   output logic           err_ovf,
   output logic           err_unf,
   output logic           wr_en,
   output logic [IW-1:0]  wr_idx,
   output logic [DW-1:0]  wr_data
);
   import stkx_pkg::*;

   localparam logic [SPW-1:0] FULL_CNT = SPW'(DEPTH);

   stk_state_e     state_q, state_d;
   logic [SPW-1:0] sp_q, sp_d, sp_m2;
   logic [AW-1:0]  addr_q;
   logic           ovf_q, ovf_d, unf_q, unf_d;
   logic           accept, is_full, is_empty, is_shallow;

   assign accept     = insn_valid && (state_q == ST_IDLE);
   assign is_full    = (sp_q == FULL_CNT);
   assign is_empty   = (sp_q == '0);
   assign is_shallow = (sp_q < SPW'(2));
   assign sp_m2      = sp_q - SPW'(2);

   always_comb begin
      state_d = state_q;
      sp_d    = sp_q;
      ovf_d   = ovf_q;
      unf_d   = unf_q;
      wr_en   = 1'b0;
      wr_idx  = sp_q[IW-1:0];
      wr_data = mem_rdata;
      case (state_q)
         ST_IDLE: if (accept) begin
            case (stk_op_e'(insn_op))
               OPC_LOAD:  if (is_full) ovf_d = 1'b1;
                          else state_d = ST_READ;
               OPC_STORE: if (is_empty) unf_d = 1'b1;
                          else state_d = ST_WRITE;
               OPC_DUP: begin
                  if (is_empty) unf_d = 1'b1;
                  else if (is_full) ovf_d = 1'b1;
                  else begin
                     wr_en   = 1'b1;
                     wr_data = top_q;
                     sp_d    = sp_q + SPW'(1);
                  end
               end
               OPC_ADD, OPC_SUB, OPC_MUL: begin
                  if (is_shallow) unf_d = 1'b1;
                  else begin
                     wr_en   = 1'b1;
                     wr_idx  = sp_m2[IW-1:0];
                     wr_data = alu_res;
                     sp_d    = sp_q - SPW'(1);
                  end
               end
               default: ;
            endcase
         end
         ST_READ: if (mem_ready) begin
            wr_en   = 1'b1;
            sp_d    = sp_q + SPW'(1);
            state_d = ST_IDLE;
         end
         ST_WRITE: if (mem_ready) begin
            sp_d    = sp_q - SPW'(1);
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sp_q    <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         sp_q    <= sp_d;
         ovf_q   <= ovf_d;
         unf_q   <= unf_d;
         if (accept) addr_q <= insn_addr;
      end
   end

   assign insn_ready = (state_q == ST_IDLE);
   assign mem_req    = (state_q != ST_IDLE);
   assign mem_we     = (state_q == ST_WRITE);
   assign mem_addr   = addr_q;
   assign sp         = sp_q;
   assign err_ovf    = ovf_q;
   assign err_unf    = unf_q;
endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit #(
   parameter int DW    = 32,
   parameter int AW    = 4,
   parameter int DEPTH = 8,
   localparam int SPW  = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           insn_valid,
   output logic           insn_ready,
   input  logic [2:0]     insn_op,
   input  logic [AW-1:0]  insn_addr,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   input  logic           mem_ready,
   output logic [SPW-1:0] depth,
   output logic [DW-1:0]  top_value,
   output logic           err_ovf,
   output logic           err_unf
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("stack_exec_unit: DEPTH must be a power of two, at least 2");
   end
   if (DW < 2 || AW < 1) begin : g_bad_width
      $error("stack_exec_unit: DW must be >= 2 and AW >= 1");
   end

   logic           wr_en;
   logic [IW-1:0]  wr_idx;
   logic [DW-1:0]  wr_data, top_q, next_q, alu_res;
   logic [SPW-1:0] sp;

   stkx_ctrl #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .SPW(SPW), .IW(IW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .insn_valid(insn_valid), .insn_op(insn_op), .insn_addr(insn_addr),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .top_q(top_q), .alu_res(alu_res),
      .insn_ready(insn_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .sp(sp), .err_ovf(err_ovf), .err_unf(err_unf),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   stkx_store #(.DW(DW), .DEPTH(DEPTH), .SPW(SPW), .IW(IW)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sp(sp), .top_q(top_q), .next_q(next_q)
   );

   stkx_alu #(.DW(DW)) u_alu (
      .op(insn_op), .lhs(next_q), .rhs(top_q), .res(alu_res)
   );

   assign mem_wdata = top_q;
   assign depth     = sp;
   assign top_value = top_q;
endmodule

// File: rtl/stkx_checker.sv
module stkx_checker #(
   parameter int DW    = 32,
   parameter int AW    = 4,
   parameter int DEPTH = 8,
   parameter int SPW   = $clog2(DEPTH + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           insn_ready,
   input logic           mem_req,
   input logic           mem_we,
   input logic           mem_ready,
   input logic [AW-1:0]  mem_addr,
   input logic [DW-1:0]  mem_wdata,
   input logic [SPW-1:0] depth,
   input logic [DW-1:0]  top_value,
   input logic           err_ovf,
   input logic           err_unf
);
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !insn_ready);

   p_wdata_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata == top_value);

   p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= SPW'(DEPTH));

   p_depth_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (depth == $past(depth)) || (depth == $past(depth) + SPW'(1))
      || (depth == $past(depth) - SPW'(1)));

   p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf |=> err_ovf);

   p_no_underflow_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_unf |=> err_unf);

   p_empty_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
      depth == '0 |-> top_value == '0);
endmodule

bind stack_exec_unit stkx_checker #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .insn_ready(insn_ready), .mem_req(mem_req),
   .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .depth(depth), .top_value(top_value),
   .err_ovf(err_ovf), .err_unf(err_unf)
);

// File: tb/sim_stack_exec_unit.sv
module sim_stack_exec_unit;
   localparam int DW = 32, AW = 4, D = 8, SPW = $clog2(D + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic insn_valid = 1'b0, insn_ready;
   logic [2:0] insn_op = '0;
   logic [AW-1:0] insn_addr = '0;
   logic mem_req, mem_we, mem_ready = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata = '0, top_value;
   logic [SPW-1:0] depth;
   logic err_ovf, err_unf;

   always #4 clk = ~clk;

   stack_exec_unit #(.DW(DW), .AW(AW), .DEPTH(D)) u0 (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
      .insn_op(insn_op), .insn_addr(insn_addr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready), .depth(depth), .top_value(top_value),
      .err_ovf(err_ovf), .err_unf(err_unf)
   );

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   logic [DW-1:0] bmem [1 << AW];
   logic [DW-1:0] mstk [D];
   int mcnt = 0;
   logic movf = 0, munf = 0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic check_state(input string req);
      chk(req, 32'(depth), 32'(mcnt));
      chk("R10", top_value, (mcnt == 0) ? '0 : mstk[mcnt-1]);
      chk("R3", 32'(err_ovf), 32'(movf));
      chk("R5", 32'(err_unf), 32'(munf));
      chk("R8", 32'(insn_ready), 32'd1);
      chk(req, 32'(mem_req), 32'd0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      mcnt = 0; movf = 0; munf = 0;
      @(negedge clk);
      chk("R1", 32'(depth), 0);
      chk("R1", 32'(err_ovf), 0);
      chk("R1", 32'(err_unf), 0);
      chk("R1", 32'(insn_ready), 1);
      chk("R1", 32'(mem_req), 0);
      chk("R1", top_value, 0);
   endtask

   task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input int waits);
      string tag;
      logic legal_mem;
      logic [DW-1:0] l, r, res;
      case (op)
         3'd0: tag = "R2";
         3'd1: tag = "R4";
         3'd2: tag = "R6";
         3'd3, 3'd4, 3'd5: tag = "R7";
         default: tag = "R9";
      endcase
      legal_mem = (op == 3'd0 && mcnt < D) || (op == 3'd1 && mcnt > 0);
      @(negedge clk);
      insn_valid = 1'b1; insn_op = op; insn_addr = a;
      @(negedge clk);
      insn_valid = 1'b0;
      if (legal_mem) begin
         chk(tag, 32'(mem_req), 1);
         chk(tag, 32'(mem_we), 32'(op == 3'd1));
         chk(tag, 32'(mem_addr), 32'(a));
         chk("R8", 32'(insn_ready), 0);
         for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk(tag, 32'(mem_req), 1);
            chk(tag, 32'(mem_addr), 32'(a));
         end
         if (op == 3'd1) begin
            chk("R4", mem_wdata, mstk[mcnt-1]);
            bmem[a] = mem_wdata;
         end
         mem_rdata = bmem[a];
         mem_ready = 1'b1;
         @(negedge clk);
         mem_ready = 1'b0;
      end
      case (op)
         3'd0: if (mcnt == D) movf = 1; else begin mstk[mcnt] = bmem[a]; mcnt++; end
         3'd1: if (mcnt == 0) munf = 1; else mcnt--;
         3'd2: if (mcnt == 0) munf = 1;
               else if (mcnt == D) movf = 1;
               else begin mstk[mcnt] = mstk[mcnt-1]; mcnt++; end
         3'd3, 3'd4, 3'd5: if (mcnt < 2) munf = 1;
               else begin
                  l = mstk[mcnt-2]; r = mstk[mcnt-1];
                  res = (op == 3'd3) ? l + r : (op == 3'd4) ? l - r : l * r;
                  mstk[mcnt-2] = res; mcnt--;
               end
         default: ;
      endcase
      check_state(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [DW-1:0] vals [6];
      logic [DW-1:0] a, b, e;
      vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
      vals[3] = 32'h8000_0000; vals[4] = 32'h7; vals[5] = 32'h1234_5678;
      for (int i = 0; i < (1 << AW); i++) bmem[i] = 32'(i) * 32'h0101_0101 + 32'h0BAD_0000;

      do_reset();
      // R2: fill the stack with varied wait states
      for (int i = 0; i < D; i++) do_op(3'd0, AW'(i), i % 3);
      // R3: overflow by load and by dup
      do_op(3'd0, AW'(9), 0);
      do_op(3'd2, '0, 0);
      // R4: store two entries
      do_op(3'd1, AW'(8), 2);
      do_op(3'd1, AW'(9), 0);
      chk("R4", bmem[8], 32'(7) * 32'h0101_0101 + 32'h0BAD_0000);
      // R6: duplicate
      do_op(3'd2, '0, 0);
      // R9: spare op codes
      do_op(3'd6, '0, 0);
      do_op(3'd7, '0, 0);

      // R7: operation sweep over corner operand pairs
      do_reset();
      for (int op = 3; op <= 5; op++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
               a = vals[i]; b = vals[j];
               bmem[10] = a; bmem[11] = b;
               do_op(3'd0, AW'(10), (i + j) % 2);
               do_op(3'd0, AW'(11), 0);
               do_op(3'(op), '0, 0);
               do_op(3'd1, AW'(12), j % 3);
               e = (op == 3) ? a + b : (op == 4) ? a - b : a * b;
               chk("R7", bmem[12], e);
            end
      // R7: back-to-back single-cycle chain (R8 keeps ready high)
      bmem[13] = 32'd5; bmem[14] = 32'd3;
      do_op(3'd0, AW'(13), 0);
      do_op(3'd0, AW'(14), 0);
      do_op(3'd2, '0, 0);
      do_op(3'd5, '0, 0);
      do_op(3'd4, '0, 0);
      chk("R7", top_value, 32'd5 - 32'd9);

      // R5: underflow cases
      do_reset();
      do_op(3'd1, AW'(3), 0);
      do_op(3'd2, '0, 0);
      do_op(3'd0, AW'(4), 1);
      do_op(3'd3, '0, 0);
      do_op(3'd4, '0, 0);
      chk("R5", top_value, bmem[4]);
      summary();
   end
endmodule